// File: doc/BRIEF.md
# Configuration DMA Command Queue

This block sits between a processor's register bus and a configuration port. Software describes a transfer by writing a source address, a destination address, a source length in 32-bit words and a destination length. The write to the destination length register commits the command into a small ordered queue. A simple engine takes commands from the queue one at a time. While the port is ready, it hands one word address per cycle to the configuration port.

A command whose source address has bit 0 set is the final transfer of an image. When its words have been delivered, the engine does not report completion straight away. It waits until the configuration port reports that it is idle, and then raises a completion bit that is separate from the ordinary one. Progress and faults are collected in a write-one-to-clear interrupt status register. A mask register selects which status bits drive the interrupt line. The block ignores all register writes until software writes a fixed key to the unlock register.

Top module: `cfgdma_cmdq`

## Requirements
- R1: After reset, the status register (0x14) reads 0x40000000, the interrupt status (0x0C) reads 0, the interrupt mask (0x10) reads 0xF8F7F87F, and `irq` is low.
- R2: Writes to any register other than the unlock register (0x34) have no effect until 0x757BDF0D is written to 0x34. A write of any other value to 0x34 leaves the block locked.
- R3: The source address (0x18), destination address (0x1C) and source length (0x20) registers hold what was written and read it back. A write to the destination length register (0x24) pushes {source address, source length} into the queue.
- R4: Status bit 31 is 1 exactly when the queue holds DEPTH commands. Status bit 30 is 1 exactly when the queue holds none.
- R5: While a command is active and `cfg_port_ready` is high, the engine asserts `cfg_word_valid` once per cycle with `cfg_word_addr` starting at the source address with bit 0 cleared and rising by 4. It delivers exactly source-length words and never asserts `cfg_word_valid` while `cfg_port_ready` is low.
- R6: An ordinary command (source address bit 0 clear) sets interrupt status bit 13 once its last word is delivered.
- R7: A final command (source address bit 0 set) sets interrupt status bit 12, and not bit 13, only once its words are delivered and `cfg_port_idle` is high.
- R8: A push while the queue is full is dropped and sets interrupt status bit 11.
- R9: A push whose source address has bit 1 or bit 2 set is not 64-bit aligned. It is dropped and sets interrupt status bit 5.
- R10: Writing to 0x0C clears each status bit written as 1. The mask register keeps only the implemented bits (0xF8F7F87F).
- R11: `irq` is high exactly when some interrupt status bit is set whose mask bit is 0.
- R12: Commands are executed in the order they were pushed.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| reg_we | input | 1 | Register write strobe |
| reg_addr | input | 8 | Register byte offset |
| reg_wdata | input | 32 | Register write data |
| reg_rdata | output | 32 | Read data for `reg_addr` (combinational) |
| cfg_port_ready | input | 1 | Port accepts a word this cycle |
| cfg_port_idle | input | 1 | Port has finished all received data |
| cfg_word_valid | output | 1 | A word is delivered this cycle |
| cfg_word_addr | output | 32 | Source address of the delivered word |
| irq | output | 1 | Interrupt request |

## Verification
The bench uses the default queue depth of 4. This lets it fill the queue with a handful of pushes while `cfg_port_ready` is held low, reach the full flag, drive one push into overflow, and then release the port to confirm the surviving commands run in order. With the small depth, a final command that is held back by `cfg_port_idle`, a misaligned push and the lock key path can each be checked in a few dozen cycles.

// File: rtl/cfgdma_pkg.sv
package cfgdma_pkg;
    localparam logic [7:0] OFS_ISTS  = 8'h0C;
    localparam logic [7:0] OFS_IMASK = 8'h10;
    localparam logic [7:0] OFS_STAT  = 8'h14;
    localparam logic [7:0] OFS_SRC   = 8'h18;
    localparam logic [7:0] OFS_DST   = 8'h1C;
    localparam logic [7:0] OFS_SLEN  = 8'h20;
    localparam logic [7:0] OFS_DLEN  = 8'h24;
    localparam logic [7:0] OFS_KEY   = 8'h34;

    localparam logic [31:0] KEY_VALUE = 32'h757B_DF0D;
    localparam logic [31:0] IMPL_BITS = 32'hF8F7_F87F;
    localparam logic [31:0] ERR_BITS  = 32'h00F0_C860;

    localparam int BIT_DMA_DONE  = 13;
    localparam int BIT_DRAIN     = 12;
    localparam int BIT_OVERFLOW  = 11;
    localparam int BIT_MISALIGN  = 5;
    localparam int BIT_Q_FULL    = 31;
    localparam int BIT_Q_EMPTY   = 30;

    typedef struct packed {
        logic [31:0] addr;
        logic [31:0] words;
    } cmd_t;

    typedef enum logic [1:0] {ENG_IDLE, ENG_RUN, ENG_DRAIN} eng_st_t;
endpackage

// File: rtl/cfgdma_fifo.sv
module cfgdma_fifo #(
    parameter int DEPTH = 4,
    parameter int W     = 64
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         push,
    input  logic [W-1:0] din,
    input  logic         pop,
    output logic [W-1:0] dout,
    output logic         full,
    output logic         empty
);
    localparam int PW = (DEPTH > 1) ? $clog2(DEPTH) : 1;
    localparam int CW = $clog2(DEPTH + 1);

    typedef struct packed {
        logic [DEPTH-1:0][W-1:0] mem;
        logic [PW-1:0]           wp;
        logic [PW-1:0]           rp;
        logic [CW-1:0]           cnt;
    } fifo_t;

    fifo_t s_q, s_d;

    function automatic logic [PW-1:0] bump(input logic [PW-1:0] p);
        return (p == PW'(DEPTH - 1)) ? '0 : p + 1'b1;
    endfunction

    assign full  = (s_q.cnt == CW'(DEPTH));
    assign empty = (s_q.cnt == '0);
    assign dout  = s_q.mem[s_q.rp];

    always_comb begin
        s_d = s_q;
        if (push && !full) begin
            s_d.mem[s_q.wp] = din;
            s_d.wp          = bump(s_q.wp);
        end
        if (pop && !empty) begin
            s_d.rp = bump(s_q.rp);
        end
        s_d.cnt = s_q.cnt + CW'(push && !full) - CW'(pop && !empty);
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            s_q <= '0;
        end else begin
            s_q <= s_d;
        end
    end

    assert_no_overflow_R8: assert property (@(posedge clk) disable iff (!rst_n)
        s_q.cnt <= CW'(DEPTH));
    assert_full_empty_apart_R4: assert property (@(posedge clk) disable iff (!rst_n)
        !(full && empty));
endmodule

// File: rtl/cfgdma_engine.sv
module cfgdma_engine
    import cfgdma_pkg::*;
(
    input  logic        clk,
    input  logic        rst_n,
    input  cmd_t        cmd,
    input  logic        cmd_avail,
    input  logic        port_ready,
    input  logic        port_idle,
    output logic        pop,
    output logic        word_valid,
    output logic [31:0] word_addr,
    output logic        done_pulse,
    output logic        drain_pulse
);
    typedef struct packed {
        eng_st_t     st;
        logic [31:0] addr;
        logic [31:0] rem;
        logic        last;
    } eng_t;

    eng_t s_q, s_d;

    assign word_addr = s_q.addr;

    always_comb begin
        logic fin;
        s_d         = s_q;
        pop         = 1'b0;
        word_valid  = 1'b0;
        done_pulse  = 1'b0;
        drain_pulse = 1'b0;
        fin         = 1'b0;
        unique case (s_q.st)
            ENG_IDLE: begin
                if (cmd_avail) begin
                    pop       = 1'b1;
                    s_d.addr  = {cmd.addr[31:1], 1'b0};
                    s_d.rem   = cmd.words;
                    s_d.last  = cmd.addr[0];
                    s_d.st    = ENG_RUN;
                end
            end
            ENG_RUN: begin
                if (s_q.rem == '0) begin
                    fin = 1'b1;
                end else if (port_ready) begin
                    word_valid = 1'b1;
                    s_d.rem    = s_q.rem - 1'b1;
                    s_d.addr   = s_q.addr + 32'd4;
                    fin        = (s_q.rem == 32'd1);
                end
                if (fin) begin
                    if (s_q.last) begin
                        s_d.st = ENG_DRAIN;
                    end else begin
                        done_pulse = 1'b1;
                        s_d.st     = ENG_IDLE;
                    end
                end
            end
            ENG_DRAIN: begin
                if (port_idle) begin
                    drain_pulse = 1'b1;
                    s_d.st      = ENG_IDLE;
                end
            end
            default: s_d.st = ENG_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            s_q <= '{st: ENG_IDLE, addr: '0, rem: '0, last: 1'b0};
        end else begin
            s_q <= s_d;
        end
    end

    assert_word_needs_ready_R5: assert property (@(posedge clk) disable iff (!rst_n)
        word_valid |-> port_ready);
endmodule

// File: rtl/cfgdma_cmdq.sv
module cfgdma_cmdq
    import cfgdma_pkg::*;
#(
    parameter int DEPTH = 4
) (
    input  logic        clk,
    input  logic        rst_n,
    input  logic        reg_we,
    input  logic [7:0]  reg_addr,
    input  logic [31:0] reg_wdata,
    output logic [31:0] reg_rdata,
    input  logic        cfg_port_ready,
    input  logic        cfg_port_idle,
    output logic        cfg_word_valid,
    output logic [31:0] cfg_word_addr,
    output logic        irq
);
    localparam int CMD_W = $bits(cmd_t);

    typedef struct packed {
        logic        unlocked;
        logic [31:0] src;
        logic [31:0] dst;
        logic [31:0] slen;
        logic [31:0] dlen;
        logic [31:0] sts;
        logic [31:0] mask;
    } regs_t;

    regs_t r_q, r_d;

    logic       q_push, q_pop, q_full, q_empty;
    cmd_t       q_out;
    logic       eng_done, eng_drain;

    cfgdma_fifo #(.DEPTH(DEPTH), .W(CMD_W)) i_fifo (
        .clk   (clk),
        .rst_n (rst_n),
        .push  (q_push),
        .din   ({r_q.src, r_q.slen}),
        .pop   (q_pop),
        .dout  (q_out),
        .full  (q_full),
        .empty (q_empty)
    );

    cfgdma_engine i_engine (
        .clk         (clk),
        .rst_n       (rst_n),
        .cmd         (q_out),
        .cmd_avail   (!q_empty),
        .port_ready  (cfg_port_ready),
        .port_idle   (cfg_port_idle),
        .pop         (q_pop),
        .word_valid  (cfg_word_valid),
        .word_addr   (cfg_word_addr),
        .done_pulse  (eng_done),
        .drain_pulse (eng_drain)
    );

    always_comb begin
        logic wr, commit, misal;
        logic [31:0] set_bits;
        r_d      = r_q;
        wr       = reg_we && r_q.unlocked;
        commit   = wr && (reg_addr == OFS_DLEN);
        misal    = (r_q.src[2:1] != 2'b00);
        set_bits = '0;
        q_push   = commit && !misal && !q_full;

        if (reg_we && reg_addr == OFS_KEY && reg_wdata == KEY_VALUE) begin
            r_d.unlocked = 1'b1;
        end
        if (wr) begin
            unique case (reg_addr)
                OFS_SRC:   r_d.src  = reg_wdata;
                OFS_DST:   r_d.dst  = reg_wdata;
                OFS_SLEN:  r_d.slen = reg_wdata;
                OFS_DLEN:  r_d.dlen = reg_wdata;
                OFS_IMASK: r_d.mask = reg_wdata & IMPL_BITS;
                OFS_ISTS:  r_d.sts  = r_q.sts & ~reg_wdata;
                default: ;
            endcase
        end

        set_bits[BIT_DMA_DONE] = eng_done;
        set_bits[BIT_DRAIN]    = eng_drain;
        set_bits[BIT_OVERFLOW] = commit && !misal && q_full;
        set_bits[BIT_MISALIGN] = commit && misal;
        r_d.sts = (r_d.sts | set_bits) & IMPL_BITS;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            r_q      <= '0;
            r_q.mask <= IMPL_BITS;
        end else begin
            r_q <= r_d;
        end
    end

    always_comb begin
        logic [31:0] stat;
        stat              = '0;
        stat[BIT_Q_FULL]  = q_full;
        stat[BIT_Q_EMPTY] = q_empty;
        unique case (reg_addr)
            OFS_ISTS:  reg_rdata = r_q.sts;
            OFS_IMASK: reg_rdata = r_q.mask;
            OFS_STAT:  reg_rdata = stat;
            OFS_SRC:   reg_rdata = r_q.src;
            OFS_DST:   reg_rdata = r_q.dst;
            OFS_SLEN:  reg_rdata = r_q.slen;
            OFS_DLEN:  reg_rdata = r_q.dlen;
            default:   reg_rdata = '0;
        endcase
    end

    assign irq = |(r_q.sts & ~r_q.mask);

    assert_locked_ignores_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (!r_q.unlocked && reg_we && reg_addr == OFS_IMASK) |=> $stable(r_q.mask));
    assert_drain_waits_port_R7: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(r_q.sts[BIT_DRAIN]) |-> $past(cfg_port_idle));
    assert_final_no_plain_done_R7: assert property (@(posedge clk) disable iff (!rst_n)
        eng_drain |-> !eng_done);
endmodule

// File: tb/test_cfgdma_cmdq.sv
`timescale 1ns/1ps
module test_cfgdma_cmdq;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        reg_we = 1'b0;
    logic [7:0]  reg_addr = '0;
    logic [31:0] reg_wdata = '0;
    logic [31:0] reg_rdata;
    logic        cfg_port_ready = 1'b1;
    logic        cfg_port_idle = 1'b1;
    logic        cfg_word_valid;
    logic [31:0] cfg_word_addr;
    logic        irq;

    int total = 0;
    int bad = 0;
    int wcount = 0;
    logic [31:0] wlog [0:63];

    always #2 clk = ~clk;

    cfgdma_cmdq #(.DEPTH(4)) i_cfgdma_cmdq (
        .clk(clk), .rst_n(rst_n), .reg_we(reg_we), .reg_addr(reg_addr),
        .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
        .cfg_port_ready(cfg_port_ready), .cfg_port_idle(cfg_port_idle),
        .cfg_word_valid(cfg_word_valid), .cfg_word_addr(cfg_word_addr), .irq(irq)
    );

    always @(posedge clk) begin
        if (cfg_word_valid) begin
            wlog[wcount[5:0]] <= cfg_word_addr;
            wcount <= wcount + 1;
        end
    end

    task automatic chk(input string req, input logic [31:0] got, input logic [31:0] exp);
        total++;
        if (got !== exp) begin
            bad++;
            $display("FAIL %s: got %h expected %h", req, got, exp);
        end
    endtask

    task automatic wr(input logic [7:0] a, input logic [31:0] d);
        @(negedge clk);
        reg_we = 1'b1; reg_addr = a; reg_wdata = d;
        @(negedge clk);
        reg_we = 1'b0;
    endtask

    task automatic rd(input logic [7:0] a, output logic [31:0] d);
        @(negedge clk);
        reg_addr = a;
        #0.5 d = reg_rdata;
    endtask

    task automatic idle(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic t_reset;
        logic [31:0] v;
        rd(8'h14, v); chk("R1 status", v, 32'h4000_0000);
        rd(8'h0C, v); chk("R1 int status", v, 32'h0);
        rd(8'h10, v); chk("R1 mask", v, 32'hF8F7_F87F);
        chk("R1 irq", {31'b0, irq}, 32'h0);
    endtask

    task automatic t_lock;
        logic [31:0] v;
        wr(8'h10, 32'h0);
        rd(8'h10, v); chk("R2 locked mask write", v, 32'hF8F7_F87F);
        wr(8'h34, 32'h1234_5678);
        wr(8'h10, 32'h0);
        rd(8'h10, v); chk("R2 wrong key", v, 32'hF8F7_F87F);
        wr(8'h34, 32'h757B_DF0D);
        wr(8'h10, 32'hFFFF_FFFF);
        rd(8'h10, v); chk("R10 mask implemented bits", v, 32'hF8F7_F87F);
    endtask

    task automatic t_single;
        logic [31:0] v;
        int base;
        base = wcount;
        wr(8'h18, 32'h0000_1000);
        wr(8'h1C, 32'hFFFF_FFFF);
        wr(8'h20, 32'd3);
        wr(8'h24, 32'd0);
        idle(10);
        chk("R5 word count", wcount - base, 32'd3);
        chk("R5 first addr", wlog[base[5:0]], 32'h0000_1000);
        chk("R5 third addr", wlog[6'(base + 2)], 32'h0000_1008);
        rd(8'h1C, v); chk("R3 dst readback", v, 32'hFFFF_FFFF);
        rd(8'h20, v); chk("R3 len readback", v, 32'd3);
        rd(8'h0C, v); chk("R6 dma done only", v, 32'h0000_2000);
        chk("R11 masked irq", {31'b0, irq}, 32'h0);
        wr(8'h10, ~32'h0000_2000);
        #0.5 chk("R11 unmasked irq", {31'b0, irq}, 32'h1);
        wr(8'h0C, 32'h0000_2000);
        rd(8'h0C, v); chk("R10 w1c", v, 32'h0);
        chk("R11 irq after clear", {31'b0, irq}, 32'h0);
    endtask

    task automatic t_last;
        logic [31:0] v;
        int base;
        base = wcount;
        cfg_port_idle = 1'b0;
        wr(8'h18, 32'h0000_2001);
        wr(8'h20, 32'd2);
        wr(8'h24, 32'd0);
        idle(10);
        chk("R7 words of final", wcount - base, 32'd2);
        chk("R7 final addr bit0 cleared", wlog[base[5:0]], 32'h0000_2000);
        rd(8'h0C, v); chk("R7 held until port idle", v, 32'h0);
        cfg_port_idle = 1'b1;
        idle(3);
        rd(8'h0C, v); chk("R7 drain done", v, 32'h0000_1000);
        wr(8'h0C, 32'hFFFF_FFFF);
    endtask

    task automatic t_overflow;
        logic [31:0] v;
        int base;
        base = wcount;
        cfg_port_ready = 1'b0;
        wr(8'h20, 32'd1);
        for (int k = 0; k < 5; k++) begin
            wr(8'h18, 32'h0000_3000 + 32'(k) * 32'h100);
            wr(8'h24, 32'd0);
        end
        idle(2);
        rd(8'h14, v); chk("R4 full flag", v, 32'h8000_0000);
        rd(8'h0C, v); chk("R8 no overflow yet", v, 32'h0);
        wr(8'h18, 32'h0000_3500);
        wr(8'h24, 32'd0);
        rd(8'h0C, v); chk("R8 overflow flag", v, 32'h0000_0800);
        chk("R5 no words while not ready", wcount - base, 32'd0);
        cfg_port_ready = 1'b1;
        idle(20);
        chk("R8 dropped push", wcount - base, 32'd5);
        for (int k = 0; k < 5; k++) begin
            chk("R12 order", wlog[6'(base + k)], 32'h0000_3000 + 32'(k) * 32'h100);
        end
        rd(8'h14, v); chk("R4 empty again", v, 32'h4000_0000);
        wr(8'h0C, 32'hFFFF_FFFF);
    endtask

    task automatic t_misalign;
        logic [31:0] v;
        int base;
        base = wcount;
        wr(8'h18, 32'h0000_4004);
        wr(8'h20, 32'd2);
        wr(8'h24, 32'd0);
        idle(8);
        chk("R9 no words", wcount - base, 32'd0);
        rd(8'h0C, v); chk("R9 misalign flag", v, 32'h0000_0020);
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        bad++; total++;
        $display("FAIL watchdog: got timeout expected completion");
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        idle(3);
        rst_n = 1'b1;
        idle(1);
        t_reset;
        t_lock;
        t_single;
        t_last;
        t_overflow;
        t_misalign;
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule